// File: doc/BRIEF.md
# Echo Region Access Monitor

This block sits beside a processor's memory bus and watches each address the processor presents. It derives the memory window that an audio signal processor reserves for its echo delay line from three configuration register values: the start page, the delay length and a control flag byte. It reports when the processor touches that window. Such an access races the signal processor's own use of the window, so software sees this report as a diagnostic.

The window begins on a 256-byte page boundary. Its length is a whole number of 2 KB blocks, set by the low four bits of the delay value. A length of zero blocks still covers a 4-byte window. The window end is computed one bit wider than the address, so a window that runs past the top of the address space stops at the top and does not wrap to address zero. One bit of the control flag byte turns checking off.

The report is one-shot. The first access that lands in the window sets a sticky flag and produces a single-cycle pulse. Later hits leave the flag set and produce no further pulse until a synchronous clear is applied. Outputs are registered, so they change on the clock edge that samples the access.

Top module: `echo_window_monitor`

## Requirements
- R1: After reset, both `hit_sticky` and `hit_pulse` are 0.
- R2: The window start is 256 times `cfg_start_page`. An access at start minus 1 does not hit, and an access at start does hit.
- R3: The window length is 2048 times `cfg_delay[3:0]`, and `cfg_delay[7:4]` has no effect. The end bound is exclusive: start plus length minus 1 hits and start plus length does not.
- R4: When `cfg_delay[3:0]` is 0, the window is 4 bytes long. Start plus 3 hits and start plus 4 does not.
- R5: The window end is computed in 17 bits. A window that reaches past 0xFFFF covers addresses up to 0xFFFF, and addresses below the start (including 0x0000) do not hit.
- R6: Checking is active only while `cfg_flags[5]` is 0. When it is 1, no access hits. The other bits of `cfg_flags` have no effect.
- R7: An access with `acc_valid` high that hits while `hit_sticky` is 0 and `hit_clear` is low sets `hit_sticky` after that clock edge. It also raises `hit_pulse` for exactly that one cycle.
- R8: While `hit_sticky` is 1, further hits leave it at 1 and produce no `hit_pulse`.
- R9: `hit_clear` high at a clock edge sets `hit_sticky` and `hit_pulse` to 0 after that edge. This takes priority over a hit in the same cycle.
- R10: An address presented with `acc_valid` low never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_start_page | input | 8 | Window start page (start = value × 256) |
| cfg_delay | input | 8 | Delay length; low nibble gives the length in 2 KB blocks |
| cfg_flags | input | 8 | Control flags; bit 5 high disables checking |
| acc_valid | input | 1 | Access strobe for `acc_addr` |
| acc_addr | input | 16 | Processor byte address |
| hit_clear | input | 1 | Synchronous clear of the sticky report |
| hit_sticky | output | 1 | Set by the first hit, held until cleared |
| hit_pulse | output | 1 | One-cycle marker of the access that set `hit_sticky` |

## Verification
The bench aims at both edges of the window. An off-by-one comparator would flag start minus 1 or miss the last byte. A design that takes the zero-block length literally would see an empty window instead of 4 bytes. A window at page 0xFF with the full length checks the 17-bit end: a truncated end would wrap and either miss 0xFFFF or flag low addresses. Further cases cover a clear that lands on the same cycle as a hit, the upper bits of the delay and flag bytes, and repeated hits after the first; a design without the one-shot rule would pulse on every one.

// File: rtl/echo_mon_pkg.sv
package echo_mon_pkg;
  // Default geometry of the monitored address space and configuration registers
  localparam int unsigned ADDR_W_D      = 16;
  localparam int unsigned CFG_W_D       = 8;
  localparam int unsigned LEN_NIB_W_D   = 4;
  localparam int unsigned PAGE_SHIFT_D  = 8;
  localparam int unsigned BLOCK_SHIFT_D = 11;
  localparam int unsigned MIN_BYTES_D   = 4;
  localparam int unsigned OFF_BIT_D     = 5;

  // Next-state bundle of the one-shot reporter
  typedef struct packed {
    logic sticky;
    logic pulse;
  } report_t;
endpackage

// File: rtl/echo_region_calc.sv
module echo_region_calc #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned LEN_NIB_W   = 4,
  parameter int unsigned PAGE_SHIFT  = 8,
  parameter int unsigned BLOCK_SHIFT = 11,
  parameter int unsigned MIN_BYTES   = 4,
  localparam int unsigned EXT_W      = ADDR_W + 1
) (
  input  logic [CFG_W-1:0] page_i,
  input  logic [CFG_W-1:0] delay_i,
  output logic [EXT_W-1:0] base_o,
  output logic [EXT_W-1:0] limit_o
);
  logic [LEN_NIB_W-1:0] blocks;
  logic [EXT_W-1:0]     span;
  logic                 unused_delay_bits;

  assign blocks            = delay_i[LEN_NIB_W-1:0];
  assign unused_delay_bits = ^delay_i;

  always_comb begin
    base_o = EXT_W'(page_i) << PAGE_SHIFT;
    if (blocks == '0) begin
      span = EXT_W'(MIN_BYTES);
    end else begin
      span = EXT_W'(blocks) << BLOCK_SHIFT;
    end
    limit_o = base_o + span;
  end
endmodule

// File: rtl/echo_hit_cmp.sv
module echo_hit_cmp #(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned EXT_W = ADDR_W + 1
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              check_off_i,
  input  logic [EXT_W-1:0]  base_i,
  input  logic [EXT_W-1:0]  limit_i,
  output logic              hit_o
);
  logic [EXT_W-1:0] addr_ext;
  logic             above_base;
  logic             below_limit;

  always_comb begin
    addr_ext    = {1'b0, addr_i};
    above_base  = (addr_ext >= base_i);
    below_limit = (addr_ext < limit_i);
    hit_o       = valid_i & ~check_off_i & above_base & below_limit;
  end
endmodule

// File: rtl/echo_sticky_flag.sv
module echo_sticky_flag
  import echo_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic sticky_o,
  output logic pulse_o
);
  report_t cur_q;
  report_t nxt;

  always_comb begin
    nxt = cur_q;
    if (clr_i) begin
      nxt.sticky = 1'b0;
      nxt.pulse  = 1'b0;
    end else begin
      nxt.pulse  = hit_i & ~cur_q.sticky;
      nxt.sticky = cur_q.sticky | hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else begin
      cur_q <= nxt;
    end
  end

  assign sticky_o = cur_q.sticky;
  assign pulse_o  = cur_q.pulse;

  assert_pulse_implies_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.pulse |-> cur_q.sticky);

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.pulse |=> !cur_q.pulse);

  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.sticky && !clr_i) |=> (cur_q.sticky && !cur_q.pulse));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!cur_q.sticky && !cur_q.pulse));
endmodule

// File: rtl/echo_window_monitor.sv
module echo_window_monitor
  import echo_mon_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_D,
  parameter int unsigned CFG_W       = CFG_W_D,
  parameter int unsigned LEN_NIB_W   = LEN_NIB_W_D,
  parameter int unsigned PAGE_SHIFT  = PAGE_SHIFT_D,
  parameter int unsigned BLOCK_SHIFT = BLOCK_SHIFT_D,
  parameter int unsigned MIN_BYTES   = MIN_BYTES_D,
  parameter int unsigned OFF_BIT     = OFF_BIT_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_start_page,
  input  logic [CFG_W-1:0]  cfg_delay,
  input  logic [CFG_W-1:0]  cfg_flags,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              hit_clear,
  output logic              hit_sticky,
  output logic              hit_pulse
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic [EXT_W-1:0] win_base;
  logic [EXT_W-1:0] win_limit;
  logic             check_off;
  logic             access_hit;
  logic             unused_flag_bits;

  assign check_off        = cfg_flags[OFF_BIT];
  assign unused_flag_bits = ^cfg_flags;

  echo_region_calc #(
    .ADDR_W      (ADDR_W),
    .CFG_W       (CFG_W),
    .LEN_NIB_W   (LEN_NIB_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .BLOCK_SHIFT (BLOCK_SHIFT),
    .MIN_BYTES   (MIN_BYTES)
  ) u_region (
    .page_i  (cfg_start_page),
    .delay_i (cfg_delay),
    .base_o  (win_base),
    .limit_o (win_limit)
  );

  echo_hit_cmp #(
    .ADDR_W (ADDR_W)
  ) u_cmp (
    .valid_i     (acc_valid),
    .addr_i      (acc_addr),
    .check_off_i (check_off),
    .base_i      (win_base),
    .limit_i     (win_limit),
    .hit_o       (access_hit)
  );

  echo_sticky_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hit_i    (access_hit),
    .clr_i    (hit_clear),
    .sticky_o (hit_sticky),
    .pulse_o  (hit_pulse)
  );

  assert_window_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    win_limit > win_base);

  assert_off_blocks_new_hit_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (check_off && !hit_sticky) |=> !hit_sticky);

  assert_idle_no_set_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!acc_valid && !hit_sticky) |=> (!hit_sticky && !hit_pulse));

  assert_below_base_no_set_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    ({1'b0, acc_addr} < win_base && !hit_sticky) |=> !hit_sticky);
endmodule

// File: tb/tb_echo_window_monitor.sv
module tb_echo_window_monitor;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_start_page;
  logic [7:0]  cfg_delay;
  logic [7:0]  cfg_flags;
  logic        acc_valid;
  logic [15:0] acc_addr;
  logic        hit_clear;
  logic        hit_sticky;
  logic        hit_pulse;

  int vectors;
  int miscompares;
  bit exp_sticky;
  bit exp_pulse;
  bit done;

  echo_window_monitor dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start_page (cfg_start_page),
    .cfg_delay      (cfg_delay),
    .cfg_flags      (cfg_flags),
    .acc_valid      (acc_valid),
    .acc_addr       (acc_addr),
    .hit_clear      (hit_clear),
    .hit_sticky     (hit_sticky),
    .hit_pulse      (hit_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit model_hit(input int pg, input int dl, input int fl,
                                   input int ad, input bit v);
    int lo;
    int len;
    if (!v) return 1'b0;
    if (((fl >> 5) & 1) != 0) return 1'b0;
    lo  = pg * 256;
    len = ((dl & 15) == 0) ? 4 : (dl & 15) * 2048;
    return (ad >= lo) && (ad < lo + len);
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (hit_sticky !== exp_sticky || hit_pulse !== exp_pulse) begin
      miscompares++;
      $display("FAIL %s: sticky/pulse actual %b/%b expected %b/%b (page %h delay %h flags %h addr %h)",
               tag, hit_sticky, hit_pulse, exp_sticky, exp_pulse,
               cfg_start_page, cfg_delay, cfg_flags, acc_addr);
    end
  endtask

  // Called at a negedge: drive, advance model, sample at the following negedge
  task automatic step(input logic [7:0] pg, input logic [7:0] dl, input logic [7:0] fl,
                      input logic [15:0] ad, input bit v, input bit c, input string tag);
    bit h;
    cfg_start_page = pg;
    cfg_delay      = dl;
    cfg_flags      = fl;
    acc_addr       = ad;
    acc_valid      = v;
    hit_clear      = c;
    h = model_hit(int'(pg), int'(dl), int'(fl), int'(ad), v);
    if (c) begin
      exp_sticky = 1'b0;
      exp_pulse  = 1'b0;
    end else begin
      exp_pulse  = h && !exp_sticky;
      exp_sticky = exp_sticky || h;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic clr();
    step(8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    done = 1'b0;
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    exp_sticky = 1'b0;
    exp_pulse = 1'b0;
    rst_n = 1'b0;
    cfg_start_page = '0;
    cfg_delay = '0;
    cfg_flags = '0;
    acc_valid = 1'b0;
    acc_addr = '0;
    hit_clear = 1'b0;
    void'($urandom(32'h5EED_0A11));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // R2: start boundary, page 0x40, one block
    step(8'h40, 8'h01, 8'h00, 16'h3FFF, 1'b1, 1'b0, "R2");
    step(8'h40, 8'h01, 8'h00, 16'h4000, 1'b1, 1'b0, "R2");
    // R7: pulse lasts a single cycle
    step(8'h40, 8'h01, 8'h00, 16'h4000, 1'b0, 1'b0, "R7");
    // R8: repeat hit gives no pulse
    step(8'h40, 8'h01, 8'h00, 16'h4010, 1'b1, 1'b0, "R8");
    clr();
    // R3: exclusive end, upper delay nibble ignored
    step(8'h40, 8'h01, 8'h00, 16'h4800, 1'b1, 1'b0, "R3");
    step(8'h40, 8'h01, 8'h00, 16'h47FF, 1'b1, 1'b0, "R3");
    clr();
    step(8'h40, 8'hF1, 8'h00, 16'h4800, 1'b1, 1'b0, "R3");
    step(8'h40, 8'hF1, 8'h00, 16'h47FF, 1'b1, 1'b0, "R3");
    clr();
    step(8'h10, 8'h03, 8'h00, 16'h27FF, 1'b1, 1'b0, "R3");
    clr();
    // R4: zero blocks gives 4 bytes
    step(8'h80, 8'h00, 8'h00, 16'h8004, 1'b1, 1'b0, "R4");
    step(8'h80, 8'h00, 8'h00, 16'h8003, 1'b1, 1'b0, "R4");
    clr();
    // R5: no wrap at top of memory
    step(8'hFF, 8'h0F, 8'h00, 16'h0000, 1'b1, 1'b0, "R5");
    step(8'hFF, 8'h0F, 8'h00, 16'hFEFF, 1'b1, 1'b0, "R5");
    step(8'hFF, 8'h0F, 8'h00, 16'hFFFF, 1'b1, 1'b0, "R5");
    clr();
    // R6: flag bit 5 disables, other bits ignored
    step(8'h80, 8'h02, 8'h20, 16'h8000, 1'b1, 1'b0, "R6");
    step(8'h80, 8'h02, 8'hFF, 16'h8100, 1'b1, 1'b0, "R6");
    step(8'h80, 8'h02, 8'hDF, 16'h8000, 1'b1, 1'b0, "R6");
    clr();
    // R10: address in window without strobe
    step(8'h80, 8'h02, 8'h00, 16'h8000, 1'b0, 1'b0, "R10");
    // R9: clear wins over a coincident hit
    step(8'h80, 8'h02, 8'h00, 16'h8000, 1'b1, 1'b1, "R9");
    step(8'h80, 8'h02, 8'h00, 16'h8001, 1'b1, 1'b0, "R7");

    // Constrained random traffic
    begin
      logic [7:0] pg, dl, fl;
      pg = 8'h20; dl = 8'h01; fl = 8'h00;
      for (int i = 0; i < 4000; i++) begin
        logic [15:0] ad;
        bit v, c, h;
        int lo, len;
        string tag;
        if (i % 40 == 0) begin
          pg = 8'($urandom);
          dl = 8'($urandom);
          if (($urandom % 4) == 0) dl[3:0] = 4'h0;
          fl = 8'($urandom);
          if (($urandom % 4) != 0) fl[5] = 1'b0;
        end
        lo  = int'(pg) * 256;
        len = (dl[3:0] == 0) ? 4 : int'(dl[3:0]) * 2048;
        if (($urandom % 2) == 0) begin
          ad = 16'(lo - 4 + int'($urandom % 32'(len + 8)));
        end else begin
          ad = 16'($urandom);
        end
        v = (($urandom % 8) != 0);
        c = (($urandom % 30) == 0);
        h = model_hit(int'(pg), int'(dl), int'(fl), int'(ad), v);
        if (c)                          tag = "R9";
        else if (fl[5] && v)            tag = "R6";
        else if (!v)                    tag = "R10";
        else if (h && !exp_sticky)      tag = "R7";
        else if (h)                     tag = "R8";
        else                            tag = "R2";
        step(pg, dl, fl, ad, v, c, tag);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule